// File: doc/BRIEF.md
# Least-significant-bit-first byte link with group flag detection

The block carries a byte stream across a one-bit wire and back. The transmit half takes bytes over a valid/ready handshake and shifts each one out over eight clocks. Bit 0 of a byte goes first and bit 7 goes last. A wire valid line marks the bits that are live. A wire frame marker rises with the first bit of any byte that was accepted with the frame-start input set. The transmitter keeps the bytes in the order it receives them. Multi-byte integer fields (for example a type value 0x0806) are therefore sent most significant byte first, which the upstream logic provides by presenting 0x08 before 0x06. Address fields are byte strings and go out in their given order.

The receive half watches the wire valid, data and frame marker. It rebuilds bytes with the first received bit as bit 0 and gives each finished byte as a one-cycle strobe, together with a flag that marks the first byte of a frame. The very first wire bit of a frame is the group (multicast) bit of the destination address. The receiver latches it at the frame marker and holds it until the next frame starts. A frame marker that arrives mid-byte drops the partial byte and starts the count again.

Top module: `lsb_wire_link`

## Requirements
- R1: Within each byte the transmitter drives bit 0 on the wire first and bit 7 last, one bit per clock while wire valid is high.
- R2: Bytes leave the wire in the order they were accepted. A type field 0x0806 presented as 0x08 then 0x06 appears as the eight bits of 0x08 followed by the eight bits of 0x06. Address bytes 12:34:56:78:9a:bc leave with 0x12 first.
- R3: Transmit ready is high when no bit is pending or when the final bit of the current byte is on the wire. Back-to-back bytes therefore leave no idle wire cycle, and after a byte is accepted ready stays low for exactly seven sampled cycles.
- R4: Wire valid is high for exactly eight cycles per accepted byte and is low when no byte is pending.
- R5: The wire frame marker is high only during the first bit of a byte accepted with frame-start set, for one cycle.
- R6: The receiver assembles eight valid wire bits into a byte, with the first received bit as bit 0. It pulses the byte strobe for one cycle in the cycle after the eighth valid bit.
- R7: The receiver ignores wire data and the frame marker in cycles where wire valid is low. Gaps do not disturb the assembly, and no byte strobe follows an idle wire cycle.
- R8: A frame marker received with a valid bit restarts the bit count at that bit. Any partial byte is discarded.
- R9: The group flag takes the value of the wire data bit that arrives with a valid frame marker. It holds that value until the next such bit.
- R10: After reset, transmit ready is high, and wire valid, the wire frame marker, the receive byte strobe and the group flag are low.
- R11: The receive first-byte flag is high with the first byte completed after a frame marker and low for the following bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter can take a byte this cycle |
| tx_data_i | input | 8 | Transmit byte |
| tx_sof_i | input | 1 | Offered byte starts a frame |
| wire_valid_o | output | 1 | Transmit wire bit is live |
| wire_data_o | output | 1 | Transmit wire bit |
| wire_sof_o | output | 1 | Transmit wire frame marker |
| wire_valid_i | input | 1 | Receive wire bit is live |
| wire_data_i | input | 1 | Receive wire bit |
| wire_sof_i | input | 1 | Receive wire frame marker |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| rx_sof_o | output | 1 | Received byte is the first of a frame |
| rx_grp_o | output | 1 | Group flag of the current frame |

## Verification
The transmitter can load a new byte in the same cycle it shifts out the last bit of the previous byte. Streaming whole frames with no pause provokes this case. The run is judged by a wire valid that stays high without a break, and by a recorded bit sequence that matches each byte in least-significant-first order when sent back through the receiver. On the receive side, a frame marker that lands partway through a byte coincides with the assembly of that byte. A driven frame cut after three bits checks that only the restarted byte and its group bit come out.

// File: rtl/lsb_wire_pkg.sv
`timescale 1ns/1ps
package lsb_wire_pkg;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/lsb_wire_tx.sv
`timescale 1ns/1ps
module lsb_wire_tx #(
  parameter int unsigned BYTE_W = lsb_wire_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_sof_i,
  output logic              ser_valid_o,
  output logic              ser_data_o,
  output logic              ser_sof_o
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic              sof_q;
  logic              load;
  logic              busy;

  assign busy       = (cnt_q != '0);
  assign in_ready_o = (cnt_q < CW'(2));   // empty or on last bit
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sof_q <= 1'b0;
    end else if (load) begin
      sh_q  <= in_data_i;
      cnt_q <= CW'(BYTE_W);
      sof_q <= in_sof_i;
    end else if (busy) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - CW'(1);
      sof_q <= 1'b0;
    end
  end

  assign ser_valid_o = busy;
  assign ser_data_o  = busy ? sh_q[0] : 1'b0;
  assign ser_sof_o   = busy && sof_q;

  p_lsb_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (ser_data_o == $past(in_data_i[0])));
  p_live_after_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> ser_valid_o);
  p_no_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_valid_o && !in_ready_o) |=> ser_valid_o);
  p_sof_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_sof_o |=> !ser_sof_o);
endmodule

// File: rtl/lsb_wire_rx.sv
`timescale 1ns/1ps
module lsb_wire_rx #(
  parameter int unsigned BYTE_W = lsb_wire_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_valid_i,
  input  logic              ser_data_i,
  input  logic              ser_sof_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_sof_o
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_nxt;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     base;
  logic              fsof_q;
  logic              first;

  always_comb begin
    base   = ser_sof_i ? '0 : cnt_q;           // marker restarts alignment
    sh_nxt = {ser_data_i, sh_q[BYTE_W-1:1]};
    first  = ser_sof_i ? 1'b1 : fsof_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      cnt_q       <= '0;
      fsof_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sof_o   <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      if (ser_valid_i) begin
        sh_q <= sh_nxt;
        if (base == CW'(BYTE_W - 1)) begin
          cnt_q       <= '0;
          fsof_q      <= 1'b0;
          out_valid_o <= 1'b1;
          out_data_o  <= sh_nxt;
          out_sof_o   <= first;
        end else begin
          cnt_q  <= base + CW'(1);
          fsof_q <= first;
        end
      end
    end
  end

  p_idle_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_valid_i |=> !out_valid_o);
  p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
endmodule

// File: rtl/lsb_wire_grp.sv
`timescale 1ns/1ps
module lsb_wire_grp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_valid_i,
  input  logic ser_data_i,
  input  logic ser_sof_i,
  output logic grp_o
);
  logic grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       grp_q <= 1'b0;
    else if (ser_valid_i && ser_sof_i) grp_q <= ser_data_i;
  end

  assign grp_o = grp_q;

  p_grp_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_valid_i && ser_sof_i) |=> (grp_o == $past(ser_data_i)));
  p_grp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ser_valid_i && ser_sof_i) |=> $stable(grp_o));
endmodule

// File: rtl/lsb_wire_link.sv
`timescale 1ns/1ps
module lsb_wire_link #(
  parameter int unsigned BYTE_W = lsb_wire_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_sof_i,
  output logic              wire_valid_o,
  output logic              wire_data_o,
  output logic              wire_sof_o,
  input  logic              wire_valid_i,
  input  logic              wire_data_i,
  input  logic              wire_sof_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_sof_o,
  output logic              rx_grp_o
);
  lsb_wire_tx #(.BYTE_W(BYTE_W)) i_tx (
    .clk_i, .rst_ni,
    .in_valid_i  (tx_valid_i),
    .in_ready_o  (tx_ready_o),
    .in_data_i   (tx_data_i),
    .in_sof_i    (tx_sof_i),
    .ser_valid_o (wire_valid_o),
    .ser_data_o  (wire_data_o),
    .ser_sof_o   (wire_sof_o)
  );

  lsb_wire_rx #(.BYTE_W(BYTE_W)) i_rx (
    .clk_i, .rst_ni,
    .ser_valid_i (wire_valid_i),
    .ser_data_i  (wire_data_i),
    .ser_sof_i   (wire_sof_i),
    .out_valid_o (rx_valid_o),
    .out_data_o  (rx_data_o),
    .out_sof_o   (rx_sof_o)
  );

  lsb_wire_grp i_grp (
    .clk_i, .rst_ni,
    .ser_valid_i (wire_valid_i),
    .ser_data_i  (wire_data_i),
    .ser_sof_i   (wire_sof_i),
    .grp_o       (rx_grp_o)
  );
endmodule

// File: tb/test_lsb_wire_link.sv
`timescale 1ns/1ps
module test_lsb_wire_link;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0, tx_sof = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic       w_valid, w_data, w_sof;
  logic       lb = 1'b0;
  logic       drv_v = 1'b0, drv_d = 1'b0, drv_s = 1'b0;
  logic       rx_valid, rx_sof, rx_grp;
  logic [7:0] rx_data;
  logic       in_v, in_d, in_s;

  int total = 0, bad = 0, cyc = 0, first_c = 0, last_c = 0;
  logic [7:0] q_rx[$];
  bit q_rxsof[$];
  bit q_bits[$];
  bit q_wsof[$];

  always #2.5 clk = ~clk;

  assign in_v = lb ? w_valid : drv_v;
  assign in_d = lb ? w_data  : drv_d;
  assign in_s = lb ? w_sof   : drv_s;

  lsb_wire_link i_lsb_wire_link (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data), .tx_sof_i(tx_sof),
    .wire_valid_o(w_valid), .wire_data_o(w_data), .wire_sof_o(w_sof),
    .wire_valid_i(in_v), .wire_data_i(in_d), .wire_sof_i(in_s),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_sof_o(rx_sof), .rx_grp_o(rx_grp)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (w_valid) begin
      if (q_bits.size() == 0) first_c <= cyc;
      last_c <= cyc;
      q_bits.push_back(w_data);
      q_wsof.push_back(w_sof);
    end
    if (rx_valid) begin
      q_rx.push_back(rx_data);
      q_rxsof.push_back(rx_sof);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    q_rx.delete(); q_rxsof.delete(); q_bits.delete(); q_wsof.delete();
  endtask

  task automatic t_reset();
    chk(tx_ready == 1'b1, "R10 ready", tx_ready, 1);
    chk(w_valid == 1'b0 && w_sof == 1'b0, "R10 wire idle", {w_valid, w_sof}, 0);
    chk(rx_valid == 1'b0, "R10 rx strobe", rx_valid, 0);
    chk(rx_grp == 1'b0, "R10 group flag", rx_grp, 0);
  endtask

  task automatic t_frame(input logic [7:0] f[$], input string name);
    int n = f.size();
    int mis = 0, sofs = 0, rxmis = 0;
    clr(); lb = 1'b1;
    for (int i = 0; i < n; i++) begin
      tx_valid = 1'b1; tx_data = f[i]; tx_sof = (i == 0);
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
    end
    tx_valid = 1'b0; tx_sof = 1'b0;
    repeat (12) @(negedge clk);
    chk(q_bits.size() == 8 * n, {"R4 bit count ", name}, q_bits.size(), 8 * n);
    chk(w_valid == 1'b0, {"R4 idle after ", name}, w_valid, 0);
    chk(last_c - first_c + 1 == q_bits.size(), {"R3 no gap ", name}, last_c - first_c + 1, q_bits.size());
    if (q_bits.size() == 8 * n)
      for (int i = 0; i < n; i++)
        for (int b = 0; b < 8; b++)
          if (q_bits[8 * i + b] != f[i][b]) mis++;
    chk(mis == 0, {"R1 R2 wire order ", name}, mis, 0);
    foreach (q_wsof[i]) if (q_wsof[i]) sofs++;
    chk(sofs == 1 && q_wsof.size() > 0 && q_wsof[0], {"R5 wire marker ", name}, sofs, 1);
    chk(q_rx.size() == n, {"R6 rx count ", name}, q_rx.size(), n);
    if (q_rx.size() == n)
      for (int i = 0; i < n; i++)
        if (q_rx[i] != f[i] || q_rxsof[i] != (i == 0)) rxmis++;
    chk(rxmis == 0, {"R6 R11 rx bytes ", name}, rxmis, 0);
    chk(rx_grp == f[0][0], {"R9 group ", name}, rx_grp, f[0][0]);
    lb = 1'b0;
  endtask

  task automatic t_ready();
    int lows = 0;
    logic last_rdy;
    tx_valid = 1'b1; tx_data = 8'hff; tx_sof = 1'b0;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k < 7 && !tx_ready) lows++;
      last_rdy = tx_ready;
      @(negedge clk);
    end
    chk(lows == 7, "R3 ready low span", lows, 7);
    chk(last_rdy == 1'b1, "R3 ready on last bit", last_rdy, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic dbit(input logic v, input logic d, input logic s);
    drv_v = v; drv_d = d; drv_s = s;
    @(negedge clk);
  endtask

  task automatic t_gaps();
    logic [7:0] a = 8'ha5, b = 8'h5a;
    clr(); lb = 1'b0;
    for (int i = 0; i < 8; i++) begin
      dbit(1'b1, a[i], i == 0);
      dbit(1'b0, ~a[i], 1'b1);   // idle cycle with noise, ignored
    end
    dbit(1'b0, 1'b0, 1'b0);
    chk(q_rx.size() == 1 && q_rx[0] == a, "R7 gapped byte", q_rx.size() > 0 ? q_rx[0] : 0, a);
    chk(q_rxsof.size() == 1 && q_rxsof[0], "R11 first flag", q_rxsof.size(), 1);
    chk(rx_grp == 1'b1, "R9 group from first bit", rx_grp, 1);
    for (int i = 0; i < 8; i++) begin
      dbit(1'b1, b[i], 1'b0);
      dbit(1'b0, 1'b0, 1'b1);
    end
    dbit(1'b0, 1'b0, 1'b0);
    chk(q_rx.size() == 2 && q_rx[1] == b, "R6 second byte", q_rx.size() > 1 ? q_rx[1] : 0, b);
    chk(q_rxsof.size() == 2 && !q_rxsof[1], "R11 later byte not first", q_rxsof.size(), 2);
    chk(rx_grp == 1'b1, "R9 group held", rx_grp, 1);
  endtask

  task automatic t_resync();
    logic [7:0] c = 8'h3c;
    clr(); lb = 1'b0;
    dbit(1'b1, 1'b1, 1'b1);
    dbit(1'b1, 1'b1, 1'b0);
    dbit(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) dbit(1'b1, c[i], i == 0);
    dbit(1'b0, 1'b0, 1'b0);
    dbit(1'b0, 1'b0, 1'b0);
    chk(q_rx.size() == 1 && q_rx[0] == c, "R8 restart byte", q_rx.size() > 0 ? q_rx[0] : 0, c);
    chk(q_rxsof.size() == 1 && q_rxsof[0], "R8 R11 restart marked first", q_rxsof.size(), 1);
    chk(rx_grp == 1'b0, "R9 group follows new frame", rx_grp, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ready();
    t_frame('{8'h12, 8'h34, 8'h56, 8'h78, 8'h9a, 8'hbc, 8'h08, 8'h06}, "address+type");
    t_frame('{8'h01, 8'hff, 8'h00, 8'h80}, "group frame");
    t_gaps();
    t_resync();
    t_frame('{8'hfe}, "single byte");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule